// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block turns a segment value and an offset into a memory address under one of three addressing schemes, chosen per request by a mode input. In the 16-bit legacy scheme the segment value is moved up by four bit positions and added to the offset, giving a 20-bit physical address that wraps within one megabyte. In the descriptor scheme a 32-bit base held in a cached descriptor is added to the offset. The offset is then compared against the cached limit, which counts in bytes or in 4096-byte pages depending on a granularity flag, and a fault flag is raised when the offset lies past the end of the segment. In the flat 64-bit scheme the descriptor base and limit are disregarded and the offset passes through as the address.

The address arithmetic is combinational. A single output register captures the address and the fault flag for each accepted request, so results appear one cycle after the request. Descriptor table reads and paging are handled elsewhere. The caller presents the descriptor fields already cached for the selected segment.

Top module: `seg_addr_gen`

## Requirements
- R1: While rst_ni is low and after its release, valid_o, fault_o and addr_o are all zero until the first request.
- R2: valid_o is high in the cycle after a cycle with req_valid_i high, and low otherwise. In a cycle with no request, addr_o keeps its previous value.
- R3: With mode_i = 2'b00 (legacy), addr_o[19:0] = seg_i*16 + offset_i[15:0], and addr_o[63:20] is zero.
- R4: In legacy mode the carry out of bit 19 is dropped, so seg_i = 16'hFFFF with offset_i[15:0] = 16'h0010 gives address 0.
- R5: Legacy mode never raises fault_o.
- R6: With mode_i = 2'b01 (descriptor), addr_o = (desc_base_i + offset_i[31:0]) mod 2^32, zero-extended to 64 bits. seg_i has no effect on the result.
- R7: In descriptor mode with desc_gran_i = 0, fault_o is high exactly when offset_i[31:0] > desc_limit_i.
- R8: In descriptor mode with desc_gran_i = 1, the limit becomes {desc_limit_i, 12'hFFF}, and fault_o is high exactly when offset_i[31:0] exceeds it.
- R9: In descriptor mode the address is still delivered per R6 when fault_o is high.
- R10: With mode_i[1] = 1 (flat, both 2'b10 and 2'b11), addr_o = offset_i across all 64 bits, whatever the base and limit hold.
- R11: Flat mode never raises fault_o.
- R12: fault_o is never high while valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe; the inputs below are captured in this cycle |
| mode_i | input | 2 | 00 legacy, 01 descriptor, 1x flat |
| seg_i | input | 16 | Segment value used in legacy mode |
| desc_base_i | input | 32 | Cached descriptor base |
| desc_limit_i | input | 20 | Cached descriptor limit |
| desc_gran_i | input | 1 | Limit unit: 0 bytes, 1 4096-byte pages |
| offset_i | input | 64 | Offset within the segment |
| valid_o | output | 1 | Result valid, one cycle after request |
| addr_o | output | 64 | Generated address |
| fault_o | output | 1 | Offset outside the segment limit |

## Verification
Random requests mix all four mode codes and full-width base, segment and offset values. These show whether each mode picks its own operands: a stray base in flat mode, or a used segment in descriptor mode, changes the address. Limits are often drawn small, so offsets fall on both sides of them under each granularity. Directed cases place the offset exactly on the limit and one past it, in byte units and in page units. This tells a strict comparison from a non-strict one, and a shifted page limit from one missing its low 12 ones. A legacy request with segment FFFF and offset 0010 exposes a carry kept past bit 19. Idle cycles between requests show whether the output holds.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int SEG_W   = 16;
  localparam int RADDR_W = 20;
  localparam int LIN_W   = 32;
  localparam int LIM_W   = 20;
  localparam int ADDR_W  = 64;
  localparam int PAGE_SH = 12;

  typedef enum logic [1:0] {
    MODE_REAL = 2'b00,
    MODE_PROT = 2'b01,
    MODE_FLAT = 2'b10,
    MODE_FLAT_ALT = 2'b11
  } addr_mode_e;
endpackage

// File: rtl/real_addr_unit.sv
module real_addr_unit #(
  parameter int SEG_W   = 16,
  parameter int RADDR_W = 20
) (
  input  logic [SEG_W-1:0]   seg_i,
  input  logic [SEG_W-1:0]   ofs_i,
  output logic [RADDR_W-1:0] addr_o
);
  localparam int SHIFT = RADDR_W - SEG_W;

  // sum truncated to RADDR_W: carry out is dropped (1 MB wrap)
  assign addr_o = {seg_i, {SHIFT{1'b0}}} + RADDR_W'(ofs_i);
endmodule

// File: rtl/prot_addr_unit.sv
module prot_addr_unit #(
  parameter int LIN_W   = 32,
  parameter int LIM_W   = 20,
  parameter int PAGE_SH = 12
) (
  input  logic [LIN_W-1:0] base_i,
  input  logic [LIM_W-1:0] limit_i,
  input  logic             gran_i,
  input  logic [LIN_W-1:0] ofs_i,
  output logic [LIN_W-1:0] addr_o,
  output logic             fault_o
);
  localparam int PLIM_W = LIM_W + PAGE_SH;

  logic [PLIM_W-1:0] page_lim;
  logic [LIN_W-1:0]  eff_lim;

  assign page_lim = {limit_i, {PAGE_SH{1'b1}}};
  assign eff_lim  = gran_i ? LIN_W'(page_lim) : LIN_W'(limit_i);
  assign addr_o   = base_i + ofs_i;
  assign fault_o  = ofs_i > eff_lim;
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        mode_i,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [LIN_W-1:0]  desc_base_i,
  input  logic [LIM_W-1:0]  desc_limit_i,
  input  logic              desc_gran_i,
  input  logic [ADDR_W-1:0] offset_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fault_o
);
  logic [RADDR_W-1:0] real_addr;
  logic [LIN_W-1:0]   prot_addr;
  logic               prot_fault;
  logic [ADDR_W-1:0]  addr_d;
  logic               fault_d;
  addr_mode_e         mode;

  assign mode = addr_mode_e'(mode_i);

  real_addr_unit #(.SEG_W(SEG_W), .RADDR_W(RADDR_W)) i_real (
    .seg_i  (seg_i),
    .ofs_i  (offset_i[SEG_W-1:0]),
    .addr_o (real_addr)
  );

  prot_addr_unit #(.LIN_W(LIN_W), .LIM_W(LIM_W), .PAGE_SH(PAGE_SH)) i_prot (
    .base_i  (desc_base_i),
    .limit_i (desc_limit_i),
    .gran_i  (desc_gran_i),
    .ofs_i   (offset_i[LIN_W-1:0]),
    .addr_o  (prot_addr),
    .fault_o (prot_fault)
  );

  always_comb begin
    unique case (mode)
      MODE_REAL: begin
        addr_d  = ADDR_W'(real_addr);
        fault_d = 1'b0;
      end
      MODE_PROT: begin
        addr_d  = ADDR_W'(prot_addr);
        fault_d = prot_fault;
      end
      default: begin
        addr_d  = offset_i;
        fault_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      fault_o <= 1'b0;
    end else begin
      valid_o <= req_valid_i;
      fault_o <= req_valid_i & fault_d;
      if (req_valid_i) addr_o <= addr_d;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> valid_o);
  // R2
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!valid_o && $stable(addr_o)));
  // R12
  fault_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> valid_o);
  // R5
  real_no_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i == 2'b00) |=> !fault_o);
  // R11
  flat_no_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i[1]) |=> !fault_o);
  // R3
  real_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i == 2'b00) |=> (addr_o[ADDR_W-1:RADDR_W] == '0));
  // R6
  prot_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i == 2'b01) |=> (addr_o[ADDR_W-1:LIN_W] == '0));
endmodule

// File: tb/test_seg_addr_gen.sv
module test_seg_addr_gen;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [15:0] seg_i = '0;
  logic [31:0] desc_base_i = '0;
  logic [19:0] desc_limit_i = '0;
  logic        desc_gran_i = 1'b0;
  logic [63:0] offset_i = '0;
  logic        valid_o;
  logic [63:0] addr_o;
  logic        fault_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  seg_addr_gen i_seg_addr_gen (.*);

  function automatic logic [63:0] exp_addr(logic [1:0] m, logic [15:0] s,
      logic [31:0] b, logic [63:0] o);
    logic [31:0] lin;
    logic [20:0] r;
    if (m[1]) return o;
    if (m == 2'b01) begin
      lin = b + o[31:0];
      return {32'h0, lin};
    end
    r = {1'b0, s, 4'h0} + {5'h0, o[15:0]};
    return {44'h0, r[19:0]};
  endfunction

  function automatic logic exp_fault(logic [1:0] m, logic [19:0] l, logic g,
      logic [63:0] o);
    logic [31:0] lim;
    if (m != 2'b01) return 1'b0;
    lim = g ? ({12'h0, l} << 12) + 32'hFFF : {12'h0, l};
    return o[31:0] > lim;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag(logic [1:0] m, logic g);
    if (m == 2'b00) return "R3/R4/R5";
    if (m == 2'b01) return g ? "R6/R8/R9" : "R6/R7/R9";
    return "R10/R11";
  endfunction

  task automatic issue(logic [1:0] m, logic [15:0] s, logic [31:0] b,
      logic [19:0] l, logic g, logic [63:0] o);
    logic [63:0] ea;
    logic ef;
    @(negedge clk_i);
    req_valid_i = 1'b1; mode_i = m; seg_i = s; desc_base_i = b;
    desc_limit_i = l; desc_gran_i = g; offset_i = o;
    ea = exp_addr(m, s, b, o);
    ef = exp_fault(m, l, g, o);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R2 valid", {63'h0, valid_o}, 64'h1);
    chk(tag(m, g), addr_o, ea);
    chk(tag(m, g), {63'h0, fault_o}, {63'h0, ef});
  endtask

  task automatic idle_check();
    logic [63:0] prev;
    prev = addr_o;
    @(negedge clk_i);
    mode_i = $urandom; offset_i = {$urandom, $urandom}; desc_base_i = $urandom;
    @(negedge clk_i);
    chk("R2 idle valid", {63'h0, valid_o}, 64'h0);
    chk("R2 idle hold", addr_o, prev);
    chk("R12 idle fault", {63'h0, fault_o}, 64'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #(CLK_PERIOD * 2);
    @(negedge clk_i);
    chk("R1 valid", {63'h0, valid_o}, 64'h0);
    chk("R1 addr", addr_o, 64'h0);
    chk("R1 fault", {63'h0, fault_o}, 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", addr_o, 64'h0);

    // R4 wrap
    issue(2'b00, 16'hFFFF, 32'h0, 20'h0, 1'b0, 64'h0010);
    issue(2'b00, 16'h1234, 32'hFFFF_FFFF, 20'h0, 1'b1, 64'hFFFF_FFFF_FFFF_5678);
    // R7 boundary
    issue(2'b01, 16'h0, 32'h0000_1000, 20'h00100, 1'b0, 64'h100);
    issue(2'b01, 16'h0, 32'h0000_1000, 20'h00100, 1'b0, 64'h101);
    // R8 boundary
    issue(2'b01, 16'h0, 32'h0, 20'h00001, 1'b1, 64'h1FFF);
    issue(2'b01, 16'h0, 32'h0, 20'h00001, 1'b1, 64'h2000);
    issue(2'b01, 16'h0, 32'h0, 20'hFFFFF, 1'b1, 64'hFFFF_FFFF);
    // R9 fault with address, wrap of base+offset
    issue(2'b01, 16'hABCD, 32'hFFFF_F000, 20'h0, 1'b0, 64'h0000_0000_0000_2000);
    // R10 base and limit ignored
    issue(2'b10, 16'h5555, 32'hDEAD_BEEF, 20'h0, 1'b0, 64'h8000_0000_0000_0001);
    issue(2'b11, 16'h5555, 32'hDEAD_BEEF, 20'h0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    idle_check();

    for (int i = 0; i < 3000; i++) begin
      logic [19:0] lim;
      lim = ($urandom % 2) ? 20'($urandom % 64) : 20'($urandom);
      issue(2'($urandom), 16'($urandom), $urandom, lim, 1'($urandom),
            ($urandom % 2) ? 64'($urandom % 20'h40000) : {$urandom, $urandom});
      if ($urandom % 8 == 0) idle_check();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule